// File: doc/BRIEF.md
# Decimal64 Operand Unpacker and Classifier

This block splits a 64-bit decimal floating-point interchange word, with its significand in densely packed form, into the parts that an arithmetic datapath needs. It delivers the sign, the 10-bit biased exponent (bias 398) and all sixteen significand digits as plain BCD. It also raises one class flag for zero, infinity, quiet NaN or signaling NaN. It sits in front of a decimal adder or multiplier, so that the later stages never see the compressed encoding.

The 5-bit combination prefix that follows the sign carries three things: the top two exponent bits, the leading significand digit, and the special-value codes. The eight continuation bits after the prefix complete the exponent. The low fifty bits are five 10-bit groups, and each group expands to three BCD digits. A parameter picks between a registered output stage (the default, one cycle of latency) and a purely combinational path.

Top module: `dec64_unpack`

## Requirements
- R1: `sign_o` equals word bit 63 (1 means negative) for every class of word.
- R2: When prefix bits 62:61 are not 11, `exp_o` is {bits 62:61, bits 57:50} and the leading digit `sig_o[63:60]` is {0, bits 60:58}, a value from 0 to 7.
- R3: When bits 62:61 are 11 and bits 60:59 are not 11, `exp_o` is {bits 60:59, bits 57:50} and the leading digit is 8 plus bit 58.
- R4: A prefix of 11110 in bits 62:58 sets `inf_o` only. In that case `exp_o` is 0 and the leading digit is 0.
- R5: A prefix of 11111 marks a NaN. Bit 57 set gives `snan_o` and bit 57 clear gives `qnan_o`. In both cases `exp_o` and the leading digit are 0, and the trailing digits are still expanded as the payload.
- R6: Group k (k = 0..4) at word bits [10k+9:10k] expands to digits 3k+2, 3k+1 and 3k. Digit i sits at `sig_o[4i+3:4i]`. Each group decodes by the densely packed rules for all 1024 codes, and the 24 redundant codes decode like the same code with its two top bits cleared.
- R7: `zero_o` is set exactly when the word is finite and all 16 digits are zero, whatever the exponent.
- R8: The word 0xA23000000000023D yields sign 1, exponent 396 and `sig_o` = 0x835, with no flag set.
- R9: With the registered stage, outputs show the word sampled at the previous rising clock edge. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 64 | Decimal64 word, densely packed significand |
| sign_o | output | 1 | Sign, 1 = negative |
| exp_o | output | 10 | Biased exponent, 0 for specials |
| sig_o | output | 64 | Sixteen BCD digits, most significant at [63:60] |
| zero_o | output | 1 | Finite with all-zero significand |
| inf_o | output | 1 | Infinity |
| qnan_o | output | 1 | Quiet NaN |
| snan_o | output | 1 | Signaling NaN |

## Verification
Every output is due exactly one rising edge after the word is applied. The word is applied on a falling edge and captured on the next rising edge. The driver queues each applied word, and a monitor compares one item 1 ns after every rising edge against a model built from the requirements. That model expands each group through a table obtained by running a digit-to-declet encoder over all 1000 digit triples, with the redundant codes folded in afterwards. Directed probes confirm that the outputs still hold the previous result just after a new word is applied. They also check the reset value while a nonzero word is driven.

// File: rtl/dec64_pkg.sv
package dec64_pkg;
  localparam int WORD_W   = 64;
  localparam int EXP_W    = 10;
  localparam int CONT_W   = 8;
  localparam int PFX_W    = 5;
  localparam int DGT_W    = 4;
  localparam int DECL_W   = 10;
  localparam int DECLETS  = 5;
  localparam int DIGITS   = 3 * DECLETS + 1;
  localparam int SIG_W    = DIGITS * DGT_W;
  localparam int TRAIL_W  = DECLETS * DECL_W;
  localparam int CONT_LSB = TRAIL_W;
  localparam int PFX_LSB  = CONT_LSB + CONT_W;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [SIG_W-1:0] sig;
    logic             zero;
    logic             inf;
    logic             qnan;
    logic             snan;
  } dec64_fields_t;
endpackage

// File: rtl/dec64_declet_dec.sv
module dec64_declet_dec
  import dec64_pkg::*;
(
  input  logic [DECL_W-1:0]  dpd_i,
  output logic [3*DGT_W-1:0] bcd_o
);
  logic [DGT_W-1:0] hi, mid, lo;
  logic [9:0] d;
  assign d = dpd_i;

  always_comb begin
    hi  = {1'b0, d[9:7]};
    mid = {1'b0, d[6:4]};
    lo  = {1'b0, d[2:0]};
    if (d[3]) begin
      unique case (d[2:1])
        2'b00: begin
          lo = {3'b100, d[0]};
        end
        2'b01: begin
          mid = {3'b100, d[4]};
          lo  = {1'b0, d[6:5], d[0]};
        end
        2'b10: begin
          hi = {3'b100, d[7]};
          lo = {1'b0, d[9:8], d[0]};
        end
        default: begin
          // two or three large digits, selected by d[6:5]
          unique case (d[6:5])
            2'b00: begin
              hi  = {3'b100, d[7]};
              mid = {3'b100, d[4]};
              lo  = {1'b0, d[9:8], d[0]};
            end
            2'b01: begin
              hi  = {3'b100, d[7]};
              mid = {1'b0, d[9:8], d[4]};
              lo  = {3'b100, d[0]};
            end
            2'b10: begin
              mid = {3'b100, d[4]};
              lo  = {3'b100, d[0]};
            end
            default: begin
              hi  = {3'b100, d[7]};
              mid = {3'b100, d[4]};
              lo  = {3'b100, d[0]};
            end
          endcase
        end
      endcase
    end
  end

  assign bcd_o = {hi, mid, lo};

  always_comb begin
    a_r6_digit_range: assert (hi <= 4'd9 && mid <= 4'd9 && lo <= 4'd9);
  end
endmodule

// File: rtl/dec64_prefix_dec.sv
module dec64_prefix_dec
  import dec64_pkg::*;
(
  input  logic [PFX_W-1:0]  pfx_i,
  input  logic [CONT_W-1:0] cont_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [DGT_W-1:0]  lead_o,
  output logic              inf_o,
  output logic              nan_o,
  output logic              snan_o
);
  logic [1:0] exp_msb;

  always_comb begin
    inf_o   = 1'b0;
    nan_o   = 1'b0;
    snan_o  = 1'b0;
    exp_msb = 2'b00;
    lead_o  = '0;
    if (pfx_i[4:1] == 4'b1111) begin
      nan_o  = pfx_i[0];
      inf_o  = ~pfx_i[0];
      snan_o = pfx_i[0] & cont_i[CONT_W-1];
    end else if (pfx_i[4:3] == 2'b11) begin
      exp_msb = pfx_i[2:1];
      lead_o  = {3'b100, pfx_i[0]};
    end else begin
      exp_msb = pfx_i[4:3];
      lead_o  = {1'b0, pfx_i[2:0]};
    end
  end

  assign exp_o = (inf_o | nan_o) ? '0 : {exp_msb, cont_i};

  always_comb begin
    a_r3_lead_range: assert (lead_o <= 4'd9);
  end
endmodule

// File: rtl/dec64_out_stage.sv
module dec64_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/dec64_unpack.sv
module dec64_unpack
  import dec64_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              zero_o,
  output logic              inf_o,
  output logic              qnan_o,
  output logic              snan_o
);
  localparam int FW = $bits(dec64_fields_t);

  logic [EXP_W-1:0] pfx_exp;
  logic [DGT_W-1:0] lead;
  logic             is_inf, is_nan, is_snan;
  logic [SIG_W-1:0] sig_d;
  dec64_fields_t    f_d, f_q;
  logic [FW-1:0]    q_vec;

  dec64_prefix_dec u_pfx (
    .pfx_i  (word_i[PFX_LSB +: PFX_W]),
    .cont_i (word_i[CONT_LSB +: CONT_W]),
    .exp_o  (pfx_exp),
    .lead_o (lead),
    .inf_o  (is_inf),
    .nan_o  (is_nan),
    .snan_o (is_snan)
  );

  generate
    for (genvar k = 0; k < DECLETS; k++) begin : g_decl
      dec64_declet_dec u_dd (
        .dpd_i (word_i[k*DECL_W +: DECL_W]),
        .bcd_o (sig_d[k*3*DGT_W +: 3*DGT_W])
      );
    end
  endgenerate

  assign sig_d[SIG_W-1 -: DGT_W] = lead;

  always_comb begin
    f_d.sign = word_i[WORD_W-1];
    f_d.expo = pfx_exp;
    f_d.sig  = sig_d;
    f_d.zero = ~(is_inf | is_nan) & (sig_d == '0);
    f_d.inf  = is_inf;
    f_d.qnan = is_nan & ~is_snan;
    f_d.snan = is_snan;
  end

  dec64_out_stage #(.W(FW), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (f_d),
    .q_o    (q_vec)
  );

  assign f_q    = dec64_fields_t'(q_vec);
  assign sign_o = f_q.sign;
  assign exp_o  = f_q.expo;
  assign sig_o  = f_q.sig;
  assign zero_o = f_q.zero;
  assign inf_o  = f_q.inf;
  assign qnan_o = f_q.qnan;
  assign snan_o = f_q.snan;

  a_r4_class_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({zero_o, inf_o, qnan_o, snan_o}));

  a_r7_zero_digits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (sig_o == '0));

  a_r5_special_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inf_o | qnan_o | snan_o) |-> (exp_o == '0 && sig_o[SIG_W-1 -: DGT_W] == '0));
endmodule

// File: tb/sim_dec64_unpack.sv
`timescale 1ns/1ps
module sim_dec64_unpack;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] word = '0;
  logic        sign_o, zero_o, inf_o, qnan_o, snan_o;
  logic [9:0]  exp_o;
  logic [63:0] sig_o;

  int total = 0;
  int bad = 0;
  logic [63:0] q[$];
  logic [11:0] ref_tab [1024];

  always #2 clk = ~clk;

  dec64_unpack u0 (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word),
    .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o),
    .zero_o(zero_o), .inf_o(inf_o), .qnan_o(qnan_o), .snan_o(snan_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // digit triple -> declet, used to build the reference expansion table
  function automatic logic [9:0] enc(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    case ({a[3], b[3], c[3]})
      3'b000: return {a[2:0], b[2:0], 1'b0, c[2:0]};
      3'b001: return {a[2:0], b[2:0], 3'b100, c[0]};
      3'b010: return {a[2:0], c[2:1], b[0], 3'b101, c[0]};
      3'b100: return {c[2:1], a[0], b[2:0], 3'b110, c[0]};
      3'b110: return {c[2:1], a[0], 2'b00, b[0], 3'b111, c[0]};
      3'b101: return {b[2:1], a[0], 2'b01, b[0], 3'b111, c[0]};
      3'b011: return {a[2:0], 2'b10, b[0], 3'b111, c[0]};
      default: return {2'b00, a[0], 2'b11, b[0], 3'b111, c[0]};
    endcase
  endfunction

  task automatic build_table();
    for (int i = 0; i < 1024; i++) ref_tab[i] = 12'hFFF;
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 10; c++)
          ref_tab[enc(4'(a), 4'(b), 4'(c))] = {4'(a), 4'(b), 4'(c)};
    for (int i = 0; i < 1024; i++)
      if (ref_tab[i] == 12'hFFF) ref_tab[i] = ref_tab[i & 10'h0FF];
  endtask

  // {sign, exp, sig, zero, inf, qnan, snan}
  function automatic logic [78:0] model(input logic [63:0] w);
    logic [4:0]  g;
    logic [9:0]  ex;
    logic [3:0]  lead;
    logic [63:0] s;
    logic        zi, ii, qi, si;
    g = w[62:58];
    ex = '0; lead = '0; ii = 0; qi = 0; si = 0;
    if (g == 5'd31) begin
      if (w[57]) si = 1; else qi = 1;
    end else if (g == 5'd30) begin
      ii = 1;
    end else if (g[4:3] != 2'b11) begin
      ex = 10'(int'(g[4:3]) * 256 + int'(w[57:50]));
      lead = {1'b0, g[2:0]};
    end else begin
      ex = 10'(int'(g[2:1]) * 256 + int'(w[57:50]));
      lead = 4'(8 + int'(g[0]));
    end
    s = '0;
    s[63:60] = lead;
    for (int k = 0; k < 5; k++) s[12*k +: 12] = ref_tab[w[10*k +: 10]];
    zi = !(ii || qi || si) && (s == 64'd0);
    return {w[63], ex, s, zi, ii, qi, si};
  endfunction

  function automatic logic [63:0] mk(input logic sg, input logic [4:0] g, input logic [7:0] ct, input logic [49:0] tr);
    return {sg, g, ct, tr};
  endfunction

  task automatic drive(input logic [63:0] w);
    @(negedge clk);
    word = w;
    q.push_back(w);
  endtask

  // scoreboard monitor
  initial begin
    logic [63:0] w;
    logic [78:0] e;
    string xt;
    wait (rst_ni);
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        w = q.pop_front();
        e = model(w);
        if (e[1]) xt = "R5"; else if (e[0]) xt = "R5";
        else if (e[2]) xt = "R4";
        else if (w[62:61] == 2'b11) xt = "R3"; else xt = "R2";
        chk(sign_o == e[78], "R1 sign", 64'(sign_o), 64'(e[78]));
        chk(exp_o == e[77:68], {xt, " exponent"}, 64'(exp_o), 64'(e[77:68]));
        chk(sig_o == e[67:4], {xt, "/R6 significand"}, sig_o, e[67:4]);
        chk(zero_o == e[3], "R7 zero flag", 64'(zero_o), 64'(e[3]));
        chk(inf_o == e[2], "R4 inf flag", 64'(inf_o), 64'(e[2]));
        chk({qnan_o, snan_o} == e[1:0], "R5 nan flags", 64'({qnan_o, snan_o}), 64'(e[1:0]));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [49:0] tr;
    build_table();
    word = 64'hA23000000000023D;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset value
    chk({sign_o, exp_o, sig_o, zero_o, inf_o, qnan_o, snan_o} == '0, "R9 reset outputs",
        sig_o, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R6 sweep of all declet codes, prefixes cycling through every class
    for (int c = 0; c < 1024; c++) begin
      tr = '0;
      tr[10*(c % 5) +: 10] = 10'(c);
      tr[10*((c + 2) % 5) +: 10] = 10'(c) ^ 10'h155;
      drive(mk(c[0], 5'((c * 7) % 32), c[9:2], tr));
    end
    // directed cases
    drive(mk(1'b0, 5'b10111, 8'hFF, 50'd0));            // R2 max exponent 767, lead 7
    drive(mk(1'b1, 5'b11001, 8'h00, 50'd0));            // R3 lead 9, exp 0
    drive(mk(1'b0, 5'b11100, 8'h12, 50'h3FF));          // R3 exp msb 10, lead 8
    drive(mk(1'b0, 5'b10000, 8'hFF, 50'd0));            // R7 zero at max exponent
    drive(mk(1'b1, 5'b00001, 8'h00, 50'd0));            // R7 lead 1 not zero
    drive(mk(1'b1, 5'b11110, 8'hAB, 50'h23D));          // R4 negative inf
    drive(mk(1'b0, 5'b11111, 8'h80, 50'h23D));          // R5 snan with payload
    drive(mk(1'b1, 5'b11111, 8'h7F, 50'h3FF_FFFF_FFFF)); // R5 qnan with payload
    drive(mk(1'b0, 5'b11111, 8'h00, 50'd0));            // R5 qnan, zero payload, not zero
    wait (q.size() == 0);
    @(posedge clk);

    // R8 literal example, R9 one-cycle latency
    @(negedge clk);
    word = 64'hA23000000000023D;
    @(posedge clk);
    #1;
    chk(sign_o == 1'b1, "R8 sign", 64'(sign_o), 64'd1);
    chk(exp_o == 10'd396, "R8 exponent", 64'(exp_o), 64'd396);
    chk(sig_o == 64'h835, "R8 significand", sig_o, 64'h835);
    chk({zero_o, inf_o, qnan_o, snan_o} == 4'b0, "R8 flags", 64'({zero_o, inf_o, qnan_o, snan_o}), 64'd0);
    @(negedge clk);
    word = mk(1'b0, 5'b11110, 8'h00, 50'd0);
    #1;
    chk(exp_o == 10'd396 && !inf_o, "R9 holds until edge", 64'(exp_o), 64'd396);
    @(posedge clk);
    #1;
    chk(inf_o && exp_o == 10'd0, "R9 updates after edge", 64'({inf_o, exp_o}), 64'h400);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule